// File: doc/BRIEF.md
# SPI Master Register and FIFO Front-End

This block is the software-facing half of a master SPI controller. A 32-bit peripheral bus reaches a small set of word-aligned registers: three configuration words, an enable bit, a slave-select field, two FIFO thresholds, two FIFO level counters, a status word, an interrupt mask and a data port. Behind the data port sit a transmit FIFO and a receive FIFO. Both have a depth set at build time and hold words of a parameterised width.

The serial engine, which lies outside this block, takes words from the head of the transmit FIFO and puts received words into the receive FIFO. It also reports whether it is busy. Software writes the configuration while the controller is disabled, then sets the enable bit and streams words through the data port. Clearing the enable bit empties both FIFOs. The transmit threshold never holds a value at or above the FIFO depth, so software can find the depth by writing increasing values and reading each one back.

Top module: `spi_regfront`

## Requirements
- R1: The byte offsets of the registers are control-A 0x00, control-B 0x04, enable 0x08, slave-select 0x10, baud divider 0x14, TX threshold 0x18, RX threshold 0x1C, TX level 0x20, RX level 0x24, status 0x28, interrupt mask 0x2C and data 0x60. Any other offset reads as 0, and writes to it are ignored.
- R2: Writes to control-A, control-B and the baud divider are ignored while the enable bit (bit 0 of 0x08) is 1. Writes to the interrupt mask, slave-select and thresholds take effect at all times.
- R3: Writing 0 to the enable bit empties both FIFOs and clears the transmit-error flag. While the block is disabled, data writes and engine puts are dropped.
- R4: Each threshold register stores the written value when that value is less than DEPTH. Otherwise it stores DEPTH-1. Write-then-read of the TX threshold therefore first differs at the value DEPTH.
- R5: The TX and RX level registers read the number of words that each FIFO holds, from 0 to DEPTH.
- R6: A data-register write pushes a word into the TX FIFO, and the engine sees the words in the same order. A data-register read returns the oldest RX word and removes it, so engine puts come back in order.
- R7: Status is 7 bits: bit0 engine busy, bit1 TX not full, bit2 TX empty, bit3 RX not empty, bit4 RX full, bit5 transmit error, bit6 collision (always 0).
- R8: A data write to a full TX FIFO while enabled is dropped and sets status bit5.
- R9: A data read from an empty RX FIFO returns 0 and leaves the RX level at 0.
- R10: Slave-select is a 4-bit one-hot field. A write with more than one of bits 3:0 set is ignored.
- R11: After reset, every register reads 0 except the interrupt mask, which reads 0xFF, and status, which reads 0x06.
- R12: eng_rx_ready is low when the RX FIFO is full or the block is disabled. An engine put at that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on the data offset) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| cfg_ctl0 | output | 16 | Control-A word |
| cfg_ctl1 | output | 16 | Control-B word |
| cfg_baud | output | 16 | Baud divider |
| cfg_ss | output | 4 | One-hot slave select |
| cfg_en | output | 1 | Controller enable |
| cfg_imask | output | 8 | Interrupt mask |
| eng_tx_valid | output | 1 | TX FIFO holds a word |
| eng_tx_word | output | DW | Oldest TX word |
| eng_tx_take | input | 1 | Engine removes the oldest TX word |
| eng_rx_put | input | 1 | Engine delivers a received word |
| eng_rx_word | input | DW | Received word |
| eng_rx_ready | output | 1 | RX FIFO accepts a put |
| eng_busy | input | 1 | Engine is shifting |

## Verification
The assertions assume that the bus raises at most one of bus_wr and bus_rd in a cycle and that bus_addr is word-aligned. They also assume that the engine asserts eng_tx_take only when it wants a word; a take against an empty FIFO is legal and has no effect. The random stimulus drives one strobe per cycle and uses only the word-aligned offsets of the map. The directed part covers unmapped offsets, take requests on an empty FIFO and puts on a full FIFO.

// File: rtl/spi_regfront.sv
module spi_regfront #(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [15:0]   cfg_ctl0,
  output logic [15:0]   cfg_ctl1,
  output logic [15:0]   cfg_baud,
  output logic [3:0]    cfg_ss,
  output logic          cfg_en,
  output logic [7:0]    cfg_imask,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_word,
  input  logic          eng_tx_take,
  input  logic          eng_rx_put,
  input  logic [DW-1:0] eng_rx_word,
  output logic          eng_rx_ready,
  input  logic          eng_busy
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  localparam logic [7:0] A_CTL0 = 8'h00, A_CTL1 = 8'h04, A_EN   = 8'h08,
                         A_SS   = 8'h10, A_BAUD = 8'h14, A_TTHR = 8'h18,
                         A_RTHR = 8'h1C, A_TLVL = 8'h20, A_RLVL = 8'h24,
                         A_STAT = 8'h28, A_IMSK = 8'h2C, A_DATA = 8'h60;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [PW-1:0] tx_thr, rx_thr;
  logic          txerr_q;

  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire flush   = bus_wr && bus_addr == A_EN && !bus_wdata[0];
  wire tx_push = wr_data && cfg_en && tx_cnt != FULL;
  wire tx_pop  = eng_tx_take && cfg_en && tx_cnt != '0;
  wire rx_push = eng_rx_put && cfg_en && rx_cnt != FULL;
  wire rx_pop  = bus_rd && bus_addr == A_DATA && rx_cnt != '0;
  wire lock    = cfg_en;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] sat(input logic [31:0] v);
    return (v >= 32'(DEPTH)) ? LAST : v[PW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ctl0 <= '0; cfg_ctl1 <= '0; cfg_baud <= '0;
      cfg_ss <= '0; cfg_en <= 1'b0; cfg_imask <= 8'hFF;
      tx_thr <= '0; rx_thr <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTL0: if (!lock) cfg_ctl0 <= bus_wdata[15:0];
        A_CTL1: if (!lock) cfg_ctl1 <= bus_wdata[15:0];
        A_BAUD: if (!lock) cfg_baud <= bus_wdata[15:0];
        A_EN:   cfg_en <= bus_wdata[0];
        A_SS:   if ($onehot0(bus_wdata[3:0])) cfg_ss <= bus_wdata[3:0];
        A_TTHR: tx_thr <= sat(bus_wdata);
        A_RTHR: rx_thr <= sat(bus_wdata);
        A_IMSK: cfg_imask <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txerr_q <= 1'b0;
    else if (flush) txerr_q <= 1'b0;
    else if (wr_data && cfg_en && tx_cnt == FULL) txerr_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (flush || !cfg_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (flush || !cfg_en) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push && !flush) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push && !flush) rx_mem[rx_wp] <= eng_rx_word;
  end

  wire [DW-1:0] rx_head = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
  wire [6:0] status = {1'b0, txerr_q, rx_cnt == FULL, rx_cnt != '0,
                       tx_cnt == '0, tx_cnt != FULL, eng_busy};

  assign eng_tx_valid = tx_cnt != '0;
  assign eng_tx_word  = eng_tx_valid ? tx_mem[tx_rp] : '0;
  assign eng_rx_ready = cfg_en && rx_cnt != FULL;

  always_comb begin
    case (bus_addr)
      A_CTL0:  bus_rdata = 32'(cfg_ctl0);
      A_CTL1:  bus_rdata = 32'(cfg_ctl1);
      A_EN:    bus_rdata = 32'(cfg_en);
      A_SS:    bus_rdata = 32'(cfg_ss);
      A_BAUD:  bus_rdata = 32'(cfg_baud);
      A_TTHR:  bus_rdata = 32'(tx_thr);
      A_RTHR:  bus_rdata = 32'(rx_thr);
      A_TLVL:  bus_rdata = 32'(tx_cnt);
      A_RLVL:  bus_rdata = 32'(rx_cnt);
      A_STAT:  bus_rdata = 32'(status);
      A_IMSK:  bus_rdata = 32'(cfg_imask);
      A_DATA:  bus_rdata = 32'(rx_head);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic          cfg_en,
  input logic [15:0]   cfg_ctl0,
  input logic [15:0]   cfg_baud,
  input logic [3:0]    cfg_ss,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [PW-1:0] tx_thr,
  input logic          txerr_q
);
  AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && bus_wr && bus_addr == 8'h00) |=> $stable(cfg_ctl0)); // R2
  AST_BAUD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && bus_wr && bus_addr == 8'h14) |=> $stable(cfg_baud)); // R2
  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (tx_cnt == '0 && rx_cnt == '0)); // R3
  AST_THR_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_thr) < 32'(DEPTH)); // R4
  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) <= 32'(DEPTH)) && (32'(rx_cnt) <= 32'(DEPTH))); // R5
  AST_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && $past(cfg_en) |-> (tx_cnt == $past(tx_cnt) ||
      tx_cnt == $past(tx_cnt) + 1'b1 || tx_cnt + 1'b1 == $past(tx_cnt))); // R6
  AST_FULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && bus_wr && bus_addr == 8'h60 && 32'(tx_cnt) == 32'(DEPTH))
    |=> txerr_q); // R8
  AST_SS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_ss)); // R10
endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cfg_en(cfg_en), .cfg_ctl0(cfg_ctl0), .cfg_baud(cfg_baud), .cfg_ss(cfg_ss),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_thr(tx_thr), .txerr_q(txerr_q)
);

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;
  localparam int DEPTH = 8;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] cfg_ctl0, cfg_ctl1, cfg_baud;
  logic [3:0] cfg_ss;
  logic cfg_en;
  logic [7:0] cfg_imask;
  logic eng_tx_valid, eng_tx_take = 0, eng_rx_put = 0, eng_rx_ready, eng_busy = 0;
  logic [DW-1:0] eng_tx_word, eng_rx_word = 0;

  int checks = 0, errors = 0;
  int txq[$];
  int rxq[$];
  logic txerr_m = 0;

  always #10 clk = ~clk;

  spi_regfront #(.DEPTH(DEPTH), .DW(DW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic take(output logic v, output logic [DW-1:0] w);
    @(negedge clk); eng_tx_take = 1;
    #2 v = eng_tx_valid; w = eng_tx_word;
    @(posedge clk); #1 eng_tx_take = 0;
  endtask

  task automatic put(input logic [DW-1:0] w, output logic rdy);
    @(negedge clk); eng_rx_put = 1; eng_rx_word = w;
    #2 rdy = eng_rx_ready;
    @(posedge clk); #1 eng_rx_put = 0;
  endtask

  function automatic logic [31:0] exp_status(input logic busy);
    return {25'd0, 1'b0, txerr_m, rxq.size() == DEPTH, rxq.size() != 0,
            txq.size() == 0, txq.size() != DEPTH, busy};
  endfunction

  function automatic logic [31:0] sat(input int v);
    return (v >= DEPTH) ? DEPTH - 1 : v;
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v, r;
    logic [DW-1:0] w;
    int found;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(8'h00, d); chk("R11 ctl0", d, 0);
    rd(8'h2C, d); chk("R11 imask", d, 32'hFF);
    rd(8'h28, d); chk("R11 R7 status", d, 32'h06);
    rd(8'h20, d); chk("R11 txlvl", d, 0);
    rd(8'h08, d); chk("R11 enable", d, 0);

    wr(8'h0C, 32'hFFFF); rd(8'h0C, d); chk("R1 unmapped 0C", d, 0);
    rd(8'h40, d); chk("R1 unmapped 40", d, 0);
    wr(8'h00, 32'h1234); rd(8'h00, d); chk("R1 ctl0 rw", d, 32'h1234);
    wr(8'h14, 32'h0010); rd(8'h14, d); chk("R1 baud rw", d, 32'h0010);

    found = 0;
    for (int i = 1; i < 300 && found == 0; i++) begin
      wr(8'h18, i); rd(8'h18, d);
      if (d != i) found = i;
    end
    chk("R4 probe depth", found, DEPTH);
    wr(8'h18, 1000); rd(8'h18, d); chk("R4 saturate", d, sat(1000));
    wr(8'h1C, 5); rd(8'h1C, d); chk("R4 rx thr", d, 5);

    wr(8'h10, 4); rd(8'h10, d); chk("R10 ss onehot", d, 4);
    wr(8'h10, 3); rd(8'h10, d); chk("R10 ss rejected", d, 4);

    wr(8'h08, 1);
    wr(8'h00, 32'hBEEF); rd(8'h00, d); chk("R2 ctl0 locked", d, 32'h1234);
    wr(8'h04, 32'h5555); rd(8'h04, d); chk("R2 ctl1 locked", d, 0);
    wr(8'h14, 32'h0002); rd(8'h14, d); chk("R2 baud locked", d, 32'h0010);
    wr(8'h2C, 32'h0F); rd(8'h2C, d); chk("R2 imask open", d, 32'h0F);

    rd(8'h60, d); chk("R9 empty read", d, 0);
    rd(8'h24, d); chk("R9 level stays", d, 0);

    for (int i = 0; i < DEPTH; i++) begin wr(8'h60, 32'hA0 + i); txq.push_back(32'hA0 + i); end
    rd(8'h20, d); chk("R5 txlvl full", d, DEPTH);
    rd(8'h28, d); chk("R7 tx full status", d, exp_status(0));
    wr(8'h60, 32'h77); txerr_m = 1;
    rd(8'h28, d); chk("R8 txerr set", d[5], 1);
    rd(8'h20, d); chk("R8 dropped", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      take(v, w); chk("R6 tx order", w, txq.pop_front());
    end
    take(v, w); chk("R6 take empty", v, 0);

    for (int i = 0; i <= DEPTH; i++) begin
      put(16'h300 + i, r);
      chk("R12 ready", r, i < DEPTH);
      if (i < DEPTH) rxq.push_back(16'h300 + i);
    end
    rd(8'h24, d); chk("R5 rxlvl", d, DEPTH);
    rd(8'h28, d); chk("R7 rx full status", d, exp_status(0));
    for (int i = 0; i < 2; i++) begin rd(8'h60, d); chk("R6 rx order", d, rxq.pop_front()); end

    wr(8'h60, 32'h11); wr(8'h60, 32'h22);
    wr(8'h08, 0); txq.delete(); rxq.delete(); txerr_m = 0;
    rd(8'h20, d); chk("R3 tx flushed", d, 0);
    rd(8'h24, d); chk("R3 rx flushed", d, 0);
    rd(8'h28, d); chk("R3 txerr cleared", d, exp_status(0));
    wr(8'h60, 32'h33); rd(8'h20, d); chk("R3 write while off", d, 0);
    put(16'h44, r); chk("R12 ready off", r, 0);
    rd(8'h24, d); chk("R3 put while off", d, 0);
    wr(8'h08, 1);

    @(negedge clk); eng_busy = 1;
    rd(8'h28, d); chk("R7 busy bit", d, exp_status(1));
    @(negedge clk); eng_busy = 0;

    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin
          int val = $urandom_range(0, 16'hFFFF);
          wr(8'h60, val);
          if (txq.size() < DEPTH) txq.push_back(val); else txerr_m = 1;
        end
        1: begin
          take(v, w);
          chk("R6 rand valid", v, txq.size() != 0);
          if (txq.size() != 0) chk("R6 rand tx word", w, txq.pop_front());
        end
        2: begin
          int val = $urandom_range(0, 16'hFFFF);
          put(val, r);
          chk("R12 rand ready", r, rxq.size() < DEPTH);
          if (rxq.size() < DEPTH) rxq.push_back(val);
        end
        3: begin
          rd(8'h60, d);
          if (rxq.size() != 0) chk("R6 rand rx word", d, rxq.pop_front());
          else chk("R9 rand empty", d, 0);
        end
        4: begin
          rd(8'h20, d); chk("R5 rand txlvl", d, txq.size());
          rd(8'h24, d); chk("R5 rand rxlvl", d, rxq.size());
        end
        default: begin
          rd(8'h28, d); chk("R7 rand status", d, exp_status(0));
        end
      endcase
    end
    summary();
  end
endmodule